// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a pipelined SIMD integer datapath for vectors of 64-bit lanes. Each accepted operation carries an accumulator vector and two multiplicand vectors. In every active lane the unit takes bits 51:0 of the two multiplicands as unsigned numbers and forms their full 104-bit product. A mode bit picks either the upper half of that product (bits 103:52) or the lower half (bits 51:0). The chosen half is zero-extended and added to the 64-bit accumulator lane, and the sum wraps modulo 2^64.

A width bit selects two active lanes (the low 128 bits) or four active lanes (all 256 bits). Lanes that are not active are driven to zero on the output. Lanes never exchange carries or product bits.

The input side is always ready. Every accepted operation comes out exactly three clock cycles later, together with its own mode and width. The unit can therefore take a new operation, with any mix of modes and widths, on every cycle.

Top module: `mac52_vec_unit`

## Requirements
- R1: Bits 63:52 of each multiplicand lane have no effect on the result.
- R2: With `in_hi_sel`=1 a lane's result is the accumulator lane plus product bits 103:52 of the unsigned 52x52 multiply, zero-extended to 64 bits.
- R3: With `in_hi_sel`=0 a lane's result is the accumulator lane plus product bits 51:0, zero-extended to 64 bits.
- R4: The lane addition wraps modulo 2^64, and every lane is computed from its own bits only (lane j occupies bits 64*j+63 down to 64*j).
- R5: With `in_wide`=0 only lanes 0 and 1 are computed, and `out_data[255:128]` is zero.
- R6: With `in_wide`=1 all four lanes are computed.
- R7: `in_ready` is 1 at all times.
- R8: `out_valid` is 1 in exactly the cycle that comes three rising edges after the edge that accepted an input with `in_valid`=1, and at no other time.
- R9: Mode and width are captured with the operands. Back-to-back operations with different settings each produce the result of their own settings.
- R10: Synchronous active-high `rst` drops all operations in flight, and `out_valid` stays 0 until a new input has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline valid bits |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Always 1 |
| in_hi_sel | input | 1 | 1: add product bits 103:52; 0: add product bits 51:0 |
| in_wide | input | 1 | 1: four lanes; 0: two lanes |
| in_acc | input | 256 | Accumulator vector, four 64-bit lanes |
| in_mul_a | input | 256 | First multiplicand vector |
| in_mul_b | input | 256 | Second multiplicand vector |
| out_valid | output | 1 | Result present on out_data |
| out_data | output | 256 | Result vector, inactive lanes zero |

## Verification
A bad partial product or a misaligned partial-sum shift corrupts only some operand patterns. Full-scale 52-bit operands, where every cross term is nonzero, therefore show it in the first result, three cycles after the input. Control bits that lose step with their data show up as a wrong half or a nonzero upper lane whenever the mode or width changes between back-to-back operations. A stuck or lost valid bit shows up as a missing or extra `out_valid` at the exact expected cycle.

// File: rtl/mac52_pkg.sv
package mac52_pkg;
   localparam int LANE_BITS    = 64;
   localparam int OPND_BITS    = 52;
   localparam int LANES_WIDE   = 4;
   localparam int LANES_NARROW = 2;
   localparam int PIPE_STAGES  = 3;
endpackage

// File: rtl/mac52_pp_split.sv
// Splits two operands into halves and forms the four cross products.
module mac52_pp_split #(
   parameter int OPND_W = 52
) (
   input  logic [OPND_W-1:0] a,
   input  logic [OPND_W-1:0] b,
   output logic [OPND_W-1:0] pp_ll,
   output logic [OPND_W-1:0] pp_lh,
   output logic [OPND_W-1:0] pp_hl,
   output logic [OPND_W-1:0] pp_hh
);
   localparam int PIECE_W = OPND_W / 2;

   logic [PIECE_W-1:0] a_lo, a_hi, b_lo, b_hi;

   assign a_lo = a[PIECE_W-1:0];
   assign a_hi = a[OPND_W-1:PIECE_W];
   assign b_lo = b[PIECE_W-1:0];
   assign b_hi = b[OPND_W-1:PIECE_W];

   assign pp_ll = {{PIECE_W{1'b0}}, a_lo} * {{PIECE_W{1'b0}}, b_lo};
   assign pp_lh = {{PIECE_W{1'b0}}, a_lo} * {{PIECE_W{1'b0}}, b_hi};
   assign pp_hl = {{PIECE_W{1'b0}}, a_hi} * {{PIECE_W{1'b0}}, b_lo};
   assign pp_hh = {{PIECE_W{1'b0}}, a_hi} * {{PIECE_W{1'b0}}, b_hi};
endmodule

// File: rtl/mac52_ctrl_pipe.sv
// Carries valid (reset) and per-operation controls (not reset) alongside data.
module mac52_ctrl_pipe #(
   parameter int DEPTH     = 3,
   parameter int CTRL_TAP  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_hi,
   input  logic in_wide,
   output logic valid_q,
   output logic hi_q,
   output logic wide_q
);
   logic [DEPTH-1:0]    vld_r;
   logic [CTRL_TAP-1:0] hi_r;
   logic [CTRL_TAP-1:0] wide_r;

   always_ff @(posedge clk) begin
      if (rst) vld_r[0] <= 1'b0;
      else     vld_r[0] <= in_valid;
      hi_r[0]   <= in_hi;
      wide_r[0] <= in_wide;
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_vld
      always_ff @(posedge clk) begin
         if (rst) vld_r[s] <= 1'b0;
         else     vld_r[s] <= vld_r[s-1];
      end
   end

   for (genvar s = 1; s < CTRL_TAP; s++) begin : g_ctl
      always_ff @(posedge clk) begin
         hi_r[s]   <= hi_r[s-1];
         wide_r[s] <= wide_r[s-1];
      end
   end

   assign valid_q = vld_r[DEPTH-1];
   assign hi_q    = hi_r[CTRL_TAP-1];
   assign wide_q  = wide_r[CTRL_TAP-1];
endmodule

// File: rtl/mac52_lane.sv
// One 64-bit lane: partial products, product sum, half select and accumulate.
module mac52_lane #(
   parameter int LANE_W = 64,
   parameter int OPND_W = 52
) (
   input  logic              clk,
   input  logic [OPND_W-1:0] s0_a,
   input  logic [OPND_W-1:0] s0_b,
   input  logic [LANE_W-1:0] s0_acc,
   input  logic              s2_hi,
   input  logic              s2_active,
   output logic [LANE_W-1:0] res
);
   localparam int PIECE_W = OPND_W / 2;
   localparam int PROD_W  = 2 * OPND_W;
   localparam int MID_W   = OPND_W + 1;
   localparam int EXT_W   = LANE_W - OPND_W;

   // stage 1: cross products
   logic [OPND_W-1:0] c_ll, c_lh, c_hl, c_hh;
   logic [OPND_W-1:0] s1_ll, s1_lh, s1_hl, s1_hh;
   logic [LANE_W-1:0] s1_acc;

   mac52_pp_split #(.OPND_W(OPND_W)) u_pp (
      .a     (s0_a),
      .b     (s0_b),
      .pp_ll (c_ll),
      .pp_lh (c_lh),
      .pp_hl (c_hl),
      .pp_hh (c_hh)
   );

   always_ff @(posedge clk) begin
      s1_ll  <= c_ll;
      s1_lh  <= c_lh;
      s1_hl  <= c_hl;
      s1_hh  <= c_hh;
      s1_acc <= s0_acc;
   end

   // stage 2: full product
   logic [MID_W-1:0]  s1_mid;
   logic [PROD_W-1:0] s1_prod;
   logic [PROD_W-1:0] s2_prod;
   logic [LANE_W-1:0] s2_acc;

   assign s1_mid  = {1'b0, s1_lh} + {1'b0, s1_hl};
   assign s1_prod = {s1_hh, s1_ll}
                  + ({{(PROD_W-MID_W){1'b0}}, s1_mid} << PIECE_W);

   always_ff @(posedge clk) begin
      s2_prod <= s1_prod;
      s2_acc  <= s1_acc;
   end

   // stage 3: half select, accumulate, lane gate
   logic [OPND_W-1:0] s2_half;
   logic [LANE_W-1:0] s2_sum;

   assign s2_half = s2_hi ? s2_prod[PROD_W-1:OPND_W] : s2_prod[OPND_W-1:0];
   assign s2_sum  = s2_acc + {{EXT_W{1'b0}}, s2_half};

   always_ff @(posedge clk) begin
      res <= s2_active ? s2_sum : '0;
   end
endmodule

// File: rtl/mac52_vec_unit.sv
module mac52_vec_unit #(
   parameter int LANE_W       = mac52_pkg::LANE_BITS,
   parameter int OPND_W       = mac52_pkg::OPND_BITS,
   parameter int MAX_LANES    = mac52_pkg::LANES_WIDE,
   parameter int NARROW_LANES = mac52_pkg::LANES_NARROW
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic                        in_hi_sel,
   input  logic                        in_wide,
   input  logic [LANE_W*MAX_LANES-1:0] in_acc,
   input  logic [LANE_W*MAX_LANES-1:0] in_mul_a,
   input  logic [LANE_W*MAX_LANES-1:0] in_mul_b,
   output logic                        out_valid,
   output logic [LANE_W*MAX_LANES-1:0] out_data
);
   localparam int STAGES = mac52_pkg::PIPE_STAGES;
   localparam int SPARE  = LANE_W - OPND_W;

   if (OPND_W % 2 != 0) begin : g_bad_opnd
      $error("OPND_W must be even");
   end
   if (OPND_W >= LANE_W) begin : g_bad_lane
      $error("OPND_W must be narrower than LANE_W");
   end
   if (NARROW_LANES < 1 || NARROW_LANES > MAX_LANES) begin : g_bad_cnt
      $error("NARROW_LANES must be in 1..MAX_LANES");
   end

   assign in_ready = 1'b1;

   logic hi_s2, wide_s2;

   mac52_ctrl_pipe #(.DEPTH(STAGES), .CTRL_TAP(STAGES-1)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_hi    (in_hi_sel),
      .in_wide  (in_wide),
      .valid_q  (out_valid),
      .hi_q     (hi_s2),
      .wide_q   (wide_s2)
   );

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
      logic              act;
      logic [2*SPARE-1:0] unused_spare;

      if (j < NARROW_LANES) begin : g_always
         assign act = 1'b1;
      end else begin : g_gated
         assign act = wide_s2;
      end

      assign unused_spare = {in_mul_a[j*LANE_W+OPND_W +: SPARE],
                             in_mul_b[j*LANE_W+OPND_W +: SPARE]};

      mac52_lane #(.LANE_W(LANE_W), .OPND_W(OPND_W)) u_lane (
         .clk       (clk),
         .s0_a      (in_mul_a[j*LANE_W +: OPND_W]),
         .s0_b      (in_mul_b[j*LANE_W +: OPND_W]),
         .s0_acc    (in_acc[j*LANE_W +: LANE_W]),
         .s2_hi     (hi_s2),
         .s2_active (act),
         .res       (out_data[j*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/mac52_chk.sv
module mac52_chk #(
   parameter int LANE_W       = 64,
   parameter int OPND_W       = 52,
   parameter int MAX_LANES    = 4,
   parameter int NARROW_LANES = 2
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic                        in_hi_sel,
   input logic                        in_wide,
   input logic [LANE_W*MAX_LANES-1:0] in_acc,
   input logic [LANE_W*MAX_LANES-1:0] in_mul_a,
   input logic [LANE_W*MAX_LANES-1:0] in_mul_b,
   input logic                        out_valid,
   input logic [LANE_W*MAX_LANES-1:0] out_data
);
   localparam int VEC_W  = LANE_W * MAX_LANES;
   localparam int PROD_W = 2 * OPND_W;

   logic [2:0] vq;
   logic [2:0] hq, wq;
   logic [LANE_W-1:0] acc_d [3];
   logic [OPND_W-1:0] a_d [3];
   logic [OPND_W-1:0] b_d [3];

   always_ff @(posedge clk) begin
      if (rst) vq <= '0;
      else     vq <= {vq[1:0], in_valid};
      hq <= {hq[1:0], in_hi_sel};
      wq <= {wq[1:0], in_wide};
      acc_d[0] <= in_acc[LANE_W-1:0];
      a_d[0]   <= in_mul_a[OPND_W-1:0];
      b_d[0]   <= in_mul_b[OPND_W-1:0];
      for (int k = 1; k < 3; k++) begin
         acc_d[k] <= acc_d[k-1];
         a_d[k]   <= a_d[k-1];
         b_d[k]   <= b_d[k-1];
      end
   end

   logic [PROD_W-1:0] m_prod;
   logic [LANE_W-1:0] m_hi, m_lo;
   assign m_prod = {{OPND_W{1'b0}}, a_d[2]} * {{OPND_W{1'b0}}, b_d[2]};
   assign m_hi = acc_d[2] + {{(LANE_W-OPND_W){1'b0}}, m_prod[PROD_W-1:OPND_W]};
   assign m_lo = acc_d[2] + {{(LANE_W-OPND_W){1'b0}}, m_prod[OPND_W-1:0]};

   assert_ready_high_R7: assert property (@(posedge clk) in_ready);

   assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid == vq[2]);

   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> !out_valid);

   assert_narrow_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !wq[2]) |-> (out_data[VEC_W-1:NARROW_LANES*LANE_W] == '0));

   assert_high_half_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && hq[2]) |-> (out_data[LANE_W-1:0] == m_hi));

   assert_low_half_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !hq[2]) |-> (out_data[LANE_W-1:0] == m_lo));
endmodule

bind mac52_vec_unit mac52_chk #(
   .LANE_W       (LANE_W),
   .OPND_W       (OPND_W),
   .MAX_LANES    (MAX_LANES),
   .NARROW_LANES (NARROW_LANES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_hi_sel (in_hi_sel),
   .in_wide   (in_wide),
   .in_acc    (in_acc),
   .in_mul_a  (in_mul_a),
   .in_mul_b  (in_mul_b),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_mac52_vec_unit.sv
`timescale 1ns/1ps
module test_mac52_vec_unit;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic         in_hi_sel = 1'b0;
   logic         in_wide = 1'b0;
   logic [255:0] in_acc = '0;
   logic [255:0] in_mul_a = '0;
   logic [255:0] in_mul_b = '0;
   logic         out_valid;
   logic [255:0] out_data;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      logic [255:0] data;
      int           due;
      string        tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;   // 200 MHz

   mac52_vec_unit i_mac52_vec_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_hi_sel(in_hi_sel), .in_wide(in_wide), .in_acc(in_acc),
      .in_mul_a(in_mul_a), .in_mul_b(in_mul_b),
      .out_valid(out_valid), .out_data(out_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [255:0] model(input logic hi, input logic wide,
         input logic [255:0] acc, input logic [255:0] a, input logic [255:0] b);
      logic [255:0] r = '0;
      for (int j = 0; j < 4; j++) begin
         if (wide || j < 2) begin
            logic [127:0] p;
            logic [63:0]  s;
            p = 128'(a[j*64 +: 52]) * 128'(b[j*64 +: 52]);
            s = hi ? 64'(p[103:52]) : 64'(p[51:0]);
            r[j*64 +: 64] = acc[j*64 +: 64] + s;
         end
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic hi, input logic wide, input logic [255:0] acc,
                       input logic [255:0] a, input logic [255:0] b, input string tag);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1; in_hi_sel = hi; in_wide = wide;
      in_acc = acc; in_mul_a = a; in_mul_b = b;
      it.data = model(hi, wide, acc, a, b);
      it.due  = cyc + 3;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_acc = {8{$urandom}};
      end
   endtask

   function automatic logic [255:0] rnd256();
      return {$urandom, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom};
   endfunction

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (!rst) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected out_valid", 256'(out_valid), 256'(0));
            end else begin
               item_t it;
               it = sb.pop_front();
               check(cyc == it.due, "R8", "result cycle", 256'(cyc), 256'(it.due));
               check(out_data == it.data, it.tag, "result data", out_data, it.data);
            end
         end else if (sb.size() != 0 && sb[0].due == cyc) begin
            check(1'b0, "R8", "missing out_valid", 256'(0), 256'(1));
            void'(sb.pop_front());
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   localparam logic [63:0] M52 = 64'h000F_FFFF_FFFF_FFFF;

   initial begin
      logic [255:0] a, b, acc;
      // reset state
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R10", "out_valid in reset", 256'(out_valid), 256'(0));
      check(in_ready == 1'b1, "R7", "in_ready in reset", 256'(in_ready), 256'(1));
      @(negedge clk); rst = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R10", "out_valid after reset", 256'(out_valid), 256'(0));
      check(in_ready == 1'b1, "R7", "in_ready idle", 256'(in_ready), 256'(1));

      // R3 low half, narrow, junk in upper lanes must be suppressed (R5)
      send(1'b0, 1'b0, {64'hAAAA, 64'hBBBB, 64'd100, 64'd7},
           {64'd9, 64'd9, 64'd1000, 64'd3}, {64'd5, 64'd5, 64'd2000, 64'd4}, "R3");
      // R2/R6 high half, wide, full-scale operands
      send(1'b1, 1'b1, '0, {4{M52}}, {4{M52}}, "R2");
      // R3/R6 low half of same full-scale product (lo half = 1)
      send(1'b0, 1'b1, {4{64'd10}}, {4{M52}}, {4{M52}}, "R6");
      // R4 wrap: all-ones accumulator plus 1
      send(1'b0, 1'b1, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'd1}}, {4{64'd1}}, "R4");
      idle(1);
      // R1 garbage in bits 63:52 of multiplicands vs clean
      a = {4{64'h0001_2345_6789_ABCD}}; b = {4{64'h000F_EDCB_A987_6543}};
      send(1'b1, 1'b1, {4{64'd77}}, a, b, "R1");
      send(1'b1, 1'b1, {4{64'd77}}, a | {4{64'hFFF0_0000_0000_0000}},
           b | {4{64'hABC0_0000_0000_0000}}, "R1");
      send(1'b0, 1'b1, {4{64'd5}}, a | {4{64'h1230_0000_0000_0000}}, b, "R1");
      idle(2);
      // R4 lane independence: distinct per-lane data, carries stay in lane
      send(1'b0, 1'b1, {64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE},
           {64'd2, M52, 64'd0, 64'd1}, {64'd3, M52, 64'd7, 64'd2}, "R4");
      // R9 back-to-back changing mode and width
      for (int k = 0; k < 12; k++) begin
         send(k[0], k[1], rnd256(), rnd256(), rnd256(), "R9");
      end
      idle(4);
      // R10 reset with operations in flight
      send(1'b1, 1'b1, rnd256(), rnd256(), rnd256(), "R10");
      send(1'b0, 1'b0, rnd256(), rnd256(), rnd256(), "R10");
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      sb.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(posedge clk); #1;
         check(out_valid == 1'b0, "R10", "flushed pipeline", 256'(out_valid), 256'(0));
      end
      // mixed traffic with bubbles
      for (int k = 0; k < 60; k++) begin
         if ($urandom_range(0, 3) == 0) idle(1);
         send($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              rnd256(), rnd256(), rnd256(), "R9");
      end
      idle(8);
      check(sb.size() == 0, "R8", "scoreboard drained", 256'(sb.size()), 256'(0));
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule